// File: doc/BRIEF.md
# Selectable Burst Address Sequencer

This block produces the effective address for a four-beat burst in a synchronous SRAM-style memory. When a new access starts, the full external address is captured into a base register and a two-bit beat counter is cleared. Each later clock edge with the advance input held low moves the burst one beat forward. The low two address bits then follow one of two orderings, picked by a static mode input. The upper address bits pass through from the captured address and never change.

Linear ordering adds the beat count to the captured low bits, modulo four. Interleaved ordering XORs the captured low bits with the beat count, which is the order some processor cache-line fills expect. Both orderings run from the same counter. Read bursts and write bursts are sequenced in the same way, so the block has no read/write input. The memory array, the data path and the control decode that produces the load and advance strobes sit outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `eff_addr_o` is all zeros and `beat_o` is 0.
- R2: One cycle after `load_i` is high at a rising edge, `eff_addr_o` equals the `start_addr_i` sampled at that edge and `beat_o` is 0.
- R3: A rising edge with `load_i` low and `adv_n_i` low raises `beat_o` by one, modulo 4, so the fifth beat returns to the start address.
- R4: With `order_sel_i` = 0 (linear), the low two bits of `eff_addr_o` equal (captured low bits + `beat_o`) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R5: With `order_sel_i` = 1 (interleaved), the low two bits equal the captured low bits XOR `beat_o`. Start 10 gives 10, 11, 00, 01, and start 11 gives 11, 10, 01, 00.
- R6: When `load_i` and an advance request (`adv_n_i` low) occur at the same edge, the load wins: the new address appears with `beat_o` = 0.
- R7: A rising edge with `load_i` low and `adv_n_i` high leaves `eff_addr_o` and `beat_o` unchanged (burst suspend).
- R8: Bits above bit 1 of `eff_addr_o` change only on a load. Advancing never modifies them.
- R9: `order_sel_i` selects the ordering combinationally. Changing it mid-burst changes the low bits of `eff_addr_o` in the same cycle and leaves `beat_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Capture a new start address and begin a burst |
| adv_n_i | input | 1 | Advance request, active low |
| order_sel_i | input | 1 | 0 = linear ordering, 1 = interleaved ordering |
| start_addr_i | input | ADDR_W | External start address |
| eff_addr_o | output | ADDR_W | Effective address: captured upper bits plus sequenced low bits |
| beat_o | output | 2 | Beat index within the current burst |

## Verification
The checker asserts on every cycle that a load captures the address and clears the beat, and that a load beats a simultaneous advance. It also asserts that a suspend holds both outputs, that an advance raises the beat by one, and that the upper bits stay put. In both orderings it asserts how the low bits relate from one beat to the next. The bench's scenarios cover the rest: the exact published sequences for particular start values, wraparound on the fifth beat, the reset value, and a mode change that takes effect in the same cycle in the middle of a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   // Burst length is fixed at four beats: two low address bits.
   localparam int unsigned LOW_W   = 2;
   localparam int unsigned N_BEATS = 1 << LOW_W;

   typedef enum logic {
      ORD_LINEAR      = 1'b0,
      ORD_INTERLEAVED = 1'b1
   } order_e;

   // Linear step: add the beat count to the start, wrapping at the burst length.
   function automatic logic [LOW_W-1:0] lin_low(input logic [LOW_W-1:0] start,
                                                input logic [LOW_W-1:0] beat);
      return start + beat;
   endfunction

   // Interleaved step: flip the start bits selected by the beat count.
   function automatic logic [LOW_W-1:0] ilv_low(input logic [LOW_W-1:0] start,
                                                input logic [LOW_W-1:0] beat);
      return start ^ beat;
   endfunction

endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg
   import burst_seq_pkg::*;
#(
   parameter int unsigned ADDR_W = 17
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic [ADDR_W-1:0]       addr_d,
   output logic [ADDR_W-LOW_W-1:0] upper_q,
   output logic [LOW_W-1:0]        start_low_q
);

   localparam int unsigned UP_W = ADDR_W - LOW_W;

   // The upper field and the seed are kept apart: only the seed feeds the sequencer.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         upper_q     <= '0;
         start_low_q <= '0;
      end else if (load) begin
         upper_q     <= addr_d[ADDR_W-1:LOW_W];
         start_low_q <= addr_d[LOW_W-1:0];
      end
   end

   if (UP_W < 1) begin : g_bad_width
      $error("burst_base_reg: ADDR_W must exceed the low field width");
   end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   output logic [CNT_W-1:0] cnt_q
);

   // Clear takes priority over step. The natural wrap of CNT_W bits closes the burst.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   if (CNT_W < 1) begin : g_bad_width
      $error("burst_beat_ctr: CNT_W must be at least one");
   end

endmodule

// File: rtl/burst_low_gen.sv
module burst_low_gen
   import burst_seq_pkg::*;
#(
   parameter bit HAS_INTERLEAVE = 1'b1
) (
   input  order_e           order,
   input  logic [LOW_W-1:0] start_low,
   input  logic [LOW_W-1:0] beat,
   output logic [LOW_W-1:0] low
);

   logic [LOW_W-1:0] lin_v;

   assign lin_v = lin_low(start_low, beat);

   if (HAS_INTERLEAVE) begin : g_both_orders
      logic [LOW_W-1:0] ilv_v;
      assign ilv_v = ilv_low(start_low, beat);
      always_comb begin
         unique case (order)
            ORD_INTERLEAVED: low = ilv_v;
            default:         low = lin_v;
         endcase
      end
   end else begin : g_linear_only
      // Variant without the XOR path: the mode input has no effect.
      order_e unused_order;
      assign unused_order = order;
      assign low = lin_v;
   end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int unsigned ADDR_W         = 17,
   parameter bit          HAS_INTERLEAVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              adv_n_i,
   input  logic              order_sel_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   output logic [ADDR_W-1:0] eff_addr_o,
   output logic [1:0]        beat_o
);

   localparam int unsigned UP_W = ADDR_W - LOW_W;

   logic [UP_W-1:0]  upper_q;
   logic [LOW_W-1:0] seed_q;
   logic [LOW_W-1:0] beat_q;
   logic [LOW_W-1:0] low_w;
   logic             step_w;
   order_e           order_w;

   assign step_w  = ~adv_n_i;
   assign order_w = order_e'(order_sel_i);

   burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (load_i),
      .addr_d      (start_addr_i),
      .upper_q     (upper_q),
      .start_low_q (seed_q)
   );

   burst_beat_ctr #(.CNT_W(LOW_W)) u_beat (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (load_i),
      .step  (step_w),
      .cnt_q (beat_q)
   );

   burst_low_gen #(.HAS_INTERLEAVE(HAS_INTERLEAVE)) u_low (
      .order     (order_w),
      .start_low (seed_q),
      .beat      (beat_q),
      .low       (low_w)
   );

   assign eff_addr_o = {upper_q, low_w};
   assign beat_o     = beat_q;

   if (ADDR_W <= LOW_W) begin : g_bad_addr
      $error("burst_addr_seq: ADDR_W must be wider than two bits");
   end
   if (N_BEATS != 4) begin : g_bad_len
      $error("burst_addr_seq: burst length must be four beats");
   end

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
   parameter int unsigned ADDR_W = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_i,
   input logic              adv_n_i,
   input logic              order_sel_i,
   input logic [ADDR_W-1:0] start_addr_i,
   input logic [ADDR_W-1:0] eff_addr_o,
   input logic [1:0]        beat_o
);

   logic [1:0]        lo;
   logic [ADDR_W-3:0] hi;
   logic [1:0]        mix;

   assign lo  = eff_addr_o[1:0];
   assign hi  = eff_addr_o[ADDR_W-1:2];
   assign mix = lo ^ beat_o;

   // R2
   p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (eff_addr_o[ADDR_W-1:2] == $past(start_addr_i[ADDR_W-1:2])) && (beat_o == 2'd0));

   // R6
   p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !adv_n_i) |=> (beat_o == 2'd0));

   // R3
   p_beat_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_n_i) |=> (beat_o == $past(beat_o) + 2'd1));

   // R7
   p_suspend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && adv_n_i) |=> ($stable(beat_o) && $stable(hi) &&
                                (($past(order_sel_i) != order_sel_i) || $stable(lo))));

   // R8
   p_upper_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(hi));

   // R4
   p_linear_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_n_i && !order_sel_i) |=>
         (order_sel_i || (lo == $past(lo) + 2'd1)));

   // R5
   p_ilv_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_n_i && order_sel_i) |=>
         (!order_sel_i || (mix == $past(mix))));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .load_i       (load_i),
   .adv_n_i      (adv_n_i),
   .order_sel_i  (order_sel_i),
   .start_addr_i (start_addr_i),
   .eff_addr_o   (eff_addr_o),
   .beat_o       (beat_o)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;

   localparam int AW = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_i = 1'b0;
   logic          adv_n_i = 1'b1;
   logic          order_sel_i = 1'b0;
   logic [AW-1:0] start_addr_i = '0;
   logic [AW-1:0] eff_addr_o;
   logic [1:0]    beat_o;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;

   // Behavioural reference: captured address and beat count.
   int m_base = 0;
   int m_beat = 0;

   always #4 clk = ~clk;

   burst_addr_seq #(.ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_n_i(adv_n_i),
      .order_sel_i(order_sel_i), .start_addr_i(start_addr_i),
      .eff_addr_o(eff_addr_o), .beat_o(beat_o)
   );

   function automatic int exp_addr();
      int s;
      int lowv;
      s = m_base & 3;
      lowv = order_sel_i ? (s ^ m_beat) : ((s + m_beat) % 4);
      return (m_base & ~3) | lowv;
   endfunction

   task automatic check_model(input string tag);
      n_run++;
      if (int'(eff_addr_o) != exp_addr() || int'(beat_o) != m_beat) begin
         n_fail++;
         $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                  tag, eff_addr_o, beat_o, exp_addr(), m_beat);
      end
   endtask

   task automatic check_low(input string tag, input int lowexp);
      n_run++;
      if (int'(eff_addr_o[1:0]) != lowexp) begin
         n_fail++;
         $display("FAIL %s: low=%0d expected %0d", tag, eff_addr_o[1:0], lowexp);
      end
   endtask

   // One clock: update the model on the edge, compare at the falling edge.
   task automatic tick(input string tag);
      @(posedge clk);
      if (!rst_n) begin m_base = 0; m_beat = 0; end
      else if (load_i) begin m_base = int'(start_addr_i); m_beat = 0; end
      else if (!adv_n_i) m_beat = (m_beat + 1) % 4;
      @(negedge clk);
      check_model(tag);
   endtask

   task automatic do_load(input int a, input bit adv);
      start_addr_i = AW'(a);
      load_i = 1'b1;
      adv_n_i = ~adv;
      tick(adv ? "R6" : "R2");
      load_i = 1'b0;
      adv_n_i = 1'b1;
   endtask

   task automatic advance(input string tag);
      adv_n_i = 1'b0;
      tick(tag);
      adv_n_i = 1'b1;
   endtask

   initial begin
      @(negedge clk);
      check_model("R1");
      tick("R1");
      rst_n = 1'b1;
      tick("R1");

      // R4: linear from 01 -> 01,10,11,00
      order_sel_i = 1'b0;
      do_load('h1A5D, 0);
      check_low("R4", 1);
      advance("R4"); check_low("R4", 2);
      advance("R4"); check_low("R4", 3);
      advance("R4"); check_low("R4", 0);
      advance("R3"); check_low("R3", 1);   // fifth beat wraps to start

      // R5: interleaved from 10 and 11
      order_sel_i = 1'b1;
      do_load('h0F3E, 0);
      check_low("R5", 2);
      advance("R5"); check_low("R5", 3);
      advance("R5"); check_low("R5", 0);
      advance("R5"); check_low("R5", 1);
      do_load('h1FFFF, 0);
      check_low("R5", 3);
      advance("R5"); check_low("R5", 2);
      advance("R5"); check_low("R5", 1);
      advance("R5"); check_low("R5", 0);
      advance("R8");

      // R7: suspend in the middle of a burst
      do_load('h0C01, 0);
      advance("R3");
      for (int i = 0; i < 3; i++) tick("R7");
      advance("R3");

      // R6: load together with advance
      do_load('h0AA2, 1);
      advance("R8");

      // R9: mode change mid-burst, same cycle
      order_sel_i = 1'b0;
      do_load('h0003, 0);
      advance("R4");                 // linear: 3+1 = 0
      check_low("R9", 0);
      order_sel_i = 1'b1;
      #1;
      check_low("R9", 2);            // interleaved: 3^1 = 2
      check_model("R9");
      advance("R5");

      // Sweep: every start, both orders, mixed advance/suspend
      for (int o = 0; o < 2; o++) begin
         for (int s = 0; s < 4; s++) begin
            order_sel_i = o[0];
            do_load((s * 'h1111 + 'h40) & 'h1FFFF | s, 0);
            for (int k = 0; k < 6; k++) begin
               adv_n_i = (k == 2);
               tick(o ? "R5" : "R4");
            end
            adv_n_i = 1'b1;
         end
      end

      // R1: reset again mid-burst
      rst_n = 1'b0;
      tick("R1");
      rst_n = 1'b1;
      tick("R1");

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #800000;
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule